// File: doc/BRIEF.md
# Shared-Bus Collision Detect and Automatic Retry

This block arbitrates bus access for a serial frame transmitter on an open-drain, point-to-multipoint line. Several stations share the line. Each one drives its transmit pin and reads the resolved bus level back on an echo input. While the block grants the framer permission to send, it compares the bit it drives with the echoed level on every sampling edge. If the two differ, another station has overridden the line. The block then ends the attempt and pulses a collision interrupt. It also takes its driver off the bus, either by releasing it to high impedance or by holding a constant '1', as set by a configuration bit.

Before any transmission, the block watches the echo input until it has seen enough consecutive high samples. The required count is 8 + 2·class + d. The class bit selects the priority level: 0 for the higher priority and 1 for the lower. The d term is 1 only when the station's previous frame ended without a collision. This makes a station that just sent wait one extra bit, which gives other stations a fair chance at the line. After a collision, the block retransmits the frame by itself once the line is idle again. It tells the framer to rewind with a one-cycle restart pulse.

Each rising clock edge is one bit time. Frame formatting, bit stuffing and checksums belong to the framer.

Top module: `bus_collision_arbiter`

## Requirements
- R1: During and straight after reset, tx_grant, coll_irq and restart_req are low and the driver is in its disabled state.
- R2: While tx_grant is high, txd_oe is 1 and txd equals frm_bit.
- R3: If txd differs from cxd at a clock edge while tx_grant is high, then in the following cycle tx_grant is low and coll_irq is high, and coll_irq is low again one cycle later.
- R4: A bit on which txd and cxd agree, including both at 0, causes no collision, and the grant stays.
- R5: While tx_grant is low, txd_oe is 0 if cfg_hold_high is 0. If cfg_hold_high is 1, txd_oe is 1 and txd is 1.
- R6: Counting starts when the block enters a waiting state. tx_grant rises in the cycle after the edge that samples the N-th consecutive high cxd, where N = 8 + 2·cfg_class + d.
- R7: d is 1 after a frame ends through frm_last with no collision. d is 0 after reset and after a collision.
- R8: A low sample of cxd while waiting restarts the count of consecutive high samples from zero.
- R9: After a collision, the block grants again without frm_req once N high samples have been seen. restart_req is high for exactly the first cycle of that grant.
- R10: Outside a retry, a new grant needs frm_req high at the edge where the idle condition holds. Idle time seen while frm_req is low still counts.
- R11: When frm_last is high at an edge with no collision, tx_grant is low in the following cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bit clock; each rising edge samples one bit |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_class | input | 1 | Priority class select (0 = higher priority, shorter wait) |
| cfg_hold_high | input | 1 | Disabled driver mode: 0 = high impedance, 1 = constant '1' |
| frm_req | input | 1 | Framer has a new frame to send |
| frm_bit | input | 1 | Bit the framer wants on the line this bit time |
| frm_last | input | 1 | Current bit is the final bit of the frame |
| cxd | input | 1 | Echoed level of the shared bus |
| tx_grant | output | 1 | Framer may send; high for each bit time of an attempt |
| txd | output | 1 | Transmit data toward the bus driver |
| txd_oe | output | 1 | Bus driver enable (0 = high impedance) |
| coll_irq | output | 1 | One-cycle collision interrupt |
| restart_req | output | 1 | One-cycle request to rewind the frame for a retry |

## Verification
txd and txd_oe follow tx_grant, frm_bit and cfg_hold_high with no delay, so the bench checks them in the same cycle it drives the inputs. tx_grant, coll_irq and restart_req are registered and change in the cycle after the deciding edge. For these, the bench counts edges from entry into a waiting state and expects the grant after exactly 8 + 2·class + d edges. Inputs are driven on the falling edge, and results are read on the falling edge after the rising edge they depend on. Each count therefore lines up exactly with a bit time.

// File: rtl/bca_pkg.sv
// Shared types for the bus collision arbiter.
// Assumes: a two-bit state encoding is enough for the control FSM.
package bca_pkg;
    typedef enum logic [1:0] {
        ST_IDLE_WAIT = 2'd0,
        ST_TRANSMIT  = 2'd1,
        ST_COLLIDED  = 2'd2
    } bca_state_e;
endpackage

// File: rtl/bca_idle_counter.sv
// Counts consecutive high samples of the bus echo and flags when the
// idle threshold BASE_IDLE + 2*cls + d is met on the current edge.
// Assumes: CNT_W can hold BASE_IDLE + 3; the count saturates at its maximum.
module bca_idle_counter #(
    parameter int BASE_IDLE = 8,
    parameter int CNT_W     = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    input  logic count_en,
    input  logic cxd,
    input  logic cls,
    input  logic d_bit,
    output logic idle_hit
);
    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};
    localparam logic [CNT_W:0]   BASE_W  = (CNT_W+1)'(BASE_IDLE);

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] cnt_inc;
    logic [CNT_W:0]   thr;

    // Saturating increment and threshold for this class and history.
    always_comb begin
        cnt_inc  = (cnt_q == CNT_MAX) ? CNT_MAX : cnt_q + 1'b1;
        thr      = BASE_W + {{(CNT_W-1){1'b0}}, cls, 1'b0} + {{CNT_W{1'b0}}, d_bit};
        idle_hit = count_en && cxd && ({1'b0, cnt_inc} >= thr);
    end

    // Run length of high samples; a low sample or a clear restarts it.
    always_ff @(posedge clk) begin
        if (!rst_n)       cnt_q <= '0;
        else if (clear)   cnt_q <= '0;
        else if (count_en) begin
            if (!cxd)     cnt_q <= '0;
            else          cnt_q <= cnt_inc;
        end
    end
endmodule

// File: rtl/bca_ctrl.sv
// Access-control FSM: waits for idle, grants transmission, aborts on a
// collision and retries on its own. Flags are registered one-cycle pulses.
// Assumes: one clock edge per bit time; mismatch is valid only in TRANSMIT.
module bca_ctrl
    import bca_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       frm_req,
    input  logic       frm_last,
    input  logic       mismatch,
    input  logic       idle_hit,
    output bca_state_e state,
    output logic       coll_pulse,
    output logic       restart_pulse,
    output logic       last_ok
);
    bca_state_e state_d;
    logic       coll_d, restart_d, last_ok_d;

    // Next-state and pulse decisions for the current bit.
    always_comb begin
        state_d   = state;
        coll_d    = 1'b0;
        restart_d = 1'b0;
        last_ok_d = last_ok;
        unique case (state)
            ST_IDLE_WAIT: if (idle_hit && frm_req) state_d = ST_TRANSMIT;
            ST_COLLIDED: if (idle_hit) begin
                state_d   = ST_TRANSMIT;
                restart_d = 1'b1;
            end
            ST_TRANSMIT: if (mismatch) begin
                state_d   = ST_COLLIDED;
                coll_d    = 1'b1;
                last_ok_d = 1'b0;
            end else if (frm_last) begin
                state_d   = ST_IDLE_WAIT;
                last_ok_d = 1'b1;
            end
            default: state_d = ST_IDLE_WAIT;
        endcase
    end

    // State, outcome history and pulse registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state         <= ST_IDLE_WAIT;
            coll_pulse    <= 1'b0;
            restart_pulse <= 1'b0;
            last_ok       <= 1'b0;
        end else begin
            state         <= state_d;
            coll_pulse    <= coll_d;
            restart_pulse <= restart_d;
            last_ok       <= last_ok_d;
        end
    end
endmodule

// File: rtl/bca_txd_drv.sv
// Transmit pin driver: passes the framer bit while active, otherwise
// applies the disabled mode (released or held at '1').
// Assumes: an external pad turns txd_oe = 0 into high impedance.
module bca_txd_drv (
    input  logic active,
    input  logic frm_bit,
    input  logic hold_high,
    output logic txd,
    output logic txd_oe
);
    // Select driven data or the disabled level.
    always_comb begin
        if (active) begin
            txd    = frm_bit;
            txd_oe = 1'b1;
        end else begin
            txd    = 1'b1;
            txd_oe = hold_high;
        end
    end
endmodule

// File: rtl/bus_collision_arbiter.sv
// Top level: collision detection and automatic retry on a shared
// open-drain serial bus. Compares txd against cxd on each bit edge.
// Assumes: clk is the bit clock and cxd is already synchronised to it.
module bus_collision_arbiter
    import bca_pkg::*;
#(
    parameter int BASE_IDLE = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cfg_class,
    input  logic cfg_hold_high,
    input  logic frm_req,
    input  logic frm_bit,
    input  logic frm_last,
    input  logic cxd,
    output logic tx_grant,
    output logic txd,
    output logic txd_oe,
    output logic coll_irq,
    output logic restart_req
);
    localparam int THR_MAX = BASE_IDLE + 3;
    localparam int CNT_W   = $clog2(THR_MAX + 1);

    bca_state_e state;
    logic       idle_hit, last_ok, mismatch, sending;

    // Decode the transmit state and compare the driven and echoed levels.
    always_comb begin
        sending  = (state == ST_TRANSMIT);
        mismatch = sending && (txd != cxd);
        tx_grant = sending;
    end

    bca_idle_counter #(
        .BASE_IDLE (BASE_IDLE),
        .CNT_W     (CNT_W)
    ) u_idle (
        .clk      (clk),
        .rst_n    (rst_n),
        .clear    (sending),
        .count_en (!sending),
        .cxd      (cxd),
        .cls      (cfg_class),
        .d_bit    (last_ok),
        .idle_hit (idle_hit)
    );

    bca_ctrl u_ctrl (
        .clk           (clk),
        .rst_n         (rst_n),
        .frm_req       (frm_req),
        .frm_last      (frm_last),
        .mismatch      (mismatch),
        .idle_hit      (idle_hit),
        .state         (state),
        .coll_pulse    (coll_irq),
        .restart_pulse (restart_req),
        .last_ok       (last_ok)
    );

    bca_txd_drv u_drv (
        .active    (sending),
        .frm_bit   (frm_bit),
        .hold_high (cfg_hold_high),
        .txd       (txd),
        .txd_oe    (txd_oe)
    );
endmodule

// File: rtl/bca_checker.sv
// Port-level properties of the bus collision arbiter, bound to every instance.
module bca_checker (
    input logic clk,
    input logic rst_n,
    input logic cfg_hold_high,
    input logic frm_bit,
    input logic frm_last,
    input logic cxd,
    input logic tx_grant,
    input logic txd,
    input logic txd_oe,
    input logic coll_irq,
    input logic restart_req
);
    // R2
    drive_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tx_grant |-> (txd_oe && (txd == frm_bit)));
    // R3
    collision_abort_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_grant && (txd != cxd)) |=> (coll_irq && !tx_grant));
    // R3
    irq_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        coll_irq |=> !coll_irq);
    // R5
    release_hiz_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!tx_grant && !cfg_hold_high) |-> !txd_oe);
    // R5
    release_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!tx_grant && cfg_hold_high) |-> (txd_oe && txd));
    // R6
    start_on_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tx_grant) |-> $past(cxd));
    // R9
    restart_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
        restart_req |-> (tx_grant && !$past(tx_grant)));
    // R11
    frame_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_grant && (txd == cxd) && frm_last) |=> !tx_grant);
endmodule

bind bus_collision_arbiter bca_checker u_bca_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .cfg_hold_high (cfg_hold_high),
    .frm_bit       (frm_bit),
    .frm_last      (frm_last),
    .cxd           (cxd),
    .tx_grant      (tx_grant),
    .txd           (txd),
    .txd_oe        (txd_oe),
    .coll_irq      (coll_irq),
    .restart_req   (restart_req)
);

// File: tb/tb_bus_collision_arbiter.sv
module tb_bus_collision_arbiter;
    logic clk = 1'b0;
    logic rst_n, cfg_class, cfg_hold_high, frm_req, frm_bit, frm_last, cxd;
    logic tx_grant, txd, txd_oe, coll_irq, restart_req;
    int   n_run = 0;
    int   n_fail = 0;

    always #5 clk = ~clk;

    bus_collision_arbiter dut (
        .clk(clk), .rst_n(rst_n), .cfg_class(cfg_class), .cfg_hold_high(cfg_hold_high),
        .frm_req(frm_req), .frm_bit(frm_bit), .frm_last(frm_last), .cxd(cxd),
        .tx_grant(tx_grant), .txd(txd), .txd_oe(txd_oe), .coll_irq(coll_irq),
        .restart_req(restart_req)
    );

    // Vector fields: [5] class, [4] send one good frame first, [3:0] expected wait
    localparam logic [5:0] VEC [0:3] = '{
        {1'b0, 1'b0, 4'd8}, {1'b1, 1'b0, 4'd10},
        {1'b0, 1'b1, 4'd9}, {1'b1, 1'b1, 4'd11}
    };

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic do_reset();
        rst_n = 1'b0; frm_req = 1'b0; frm_bit = 1'b1; frm_last = 1'b0; cxd = 1'b1;
        step(); step();
        rst_n = 1'b1;
    endtask

    task automatic wait_grant(output int n);
        n = 0;
        while (!tx_grant && n < 40) begin
            step();
            n++;
        end
    endtask

    task automatic good_frame();
        frm_bit = 1'b1; cxd = 1'b1; frm_last = 1'b0;
        step();
        frm_last = 1'b1;
        step();
        frm_last = 1'b0;
    endtask

    initial begin
        int n;
        cfg_class = 1'b0; cfg_hold_high = 1'b0;
        do_reset();
        #1;
        // R1 reset state
        check(!tx_grant && !coll_irq && !restart_req && !txd_oe, "R1", tx_grant, 0);

        // Table walk: R6 and R7 wait lengths
        foreach (VEC[i]) begin
            do_reset();
            cfg_class = VEC[i][5];
            frm_req = 1'b1;
            if (VEC[i][4]) begin
                wait_grant(n);
                check(n == 8 + 2 * int'(VEC[i][5]), "R6", n, 8 + 2 * int'(VEC[i][5]));
                good_frame();
                check(!tx_grant, "R11", tx_grant, 0);
            end
            wait_grant(n);
            check(n == int'(VEC[i][3:0]), "R6/R7 table", n, int'(VEC[i][3:0]));
        end

        // Collision and automatic retry
        do_reset();
        cfg_class = 1'b0; cfg_hold_high = 1'b0; frm_req = 1'b1;
        wait_grant(n);
        good_frame();
        wait_grant(n);
        check(n == 9, "R7 d after good frame", n, 9);
        frm_bit = 1'b0; cxd = 1'b0; #1;
        check(txd_oe && txd == 1'b0, "R2", txd, 0);
        step();
        check(tx_grant && !coll_irq, "R4 both low", coll_irq, 0);
        frm_bit = 1'b1; cxd = 1'b0;
        step();
        check(coll_irq && !tx_grant, "R3 abort", coll_irq, 1);
        check(!txd_oe, "R5 hiz", txd_oe, 0);
        frm_req = 1'b0; cxd = 1'b1; cfg_hold_high = 1'b1; #1;
        check(txd_oe && txd, "R5 hold high", txd_oe, 1);
        step();
        check(!coll_irq, "R3 pulse width", coll_irq, 0);
        wait_grant(n);
        check(n + 1 == 8, "R7 d cleared / R9 retry", n + 1, 8);
        check(tx_grant && restart_req, "R9 restart pulse", restart_req, 1);
        frm_bit = 1'b1; cxd = 1'b1; frm_last = 1'b1;
        step();
        frm_last = 1'b0;
        check(!restart_req && !tx_grant, "R9/R11", restart_req, 0);

        // R8 low sample restarts the count (class 0, d = 1 so wait is 9)
        frm_req = 1'b1; cfg_hold_high = 1'b0;
        repeat (5) step();
        cxd = 1'b0;
        step();
        check(!tx_grant, "R8 no early grant", tx_grant, 0);
        cxd = 1'b1;
        wait_grant(n);
        check(n == 9, "R8", n, 9);

        // R10 no request, no grant; idle time still counts
        do_reset();
        repeat (20) step();
        check(!tx_grant, "R10 no request", tx_grant, 0);
        frm_req = 1'b1;
        step();
        check(tx_grant, "R10 grant on request", tx_grant, 1);

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_fail++;
        n_run++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule